// File: doc/BRIEF.md
# Converter Serial Command and Result Port

This block is the device side of the serial link on a small multi-channel data converter. The host pulls an active-low select line low, toggles a serial clock and shifts bits in. The port skips any leading zeros until the first one. It takes that one as the start marker and then captures a short configuration word. The word holds a channel selection and an output-order flag. The port passes these to the converter core and raises a start-of-conversion strobe.

Once the word is in, the port turns on its data output and sends a null bit and then the result, most significant bit first. When the order flag is clear, the result is sent a second time, least significant bit first, and the two sequences share B0. Raising the select line ends the exchange at once, so a host can abort at any point.

Input bits are sampled on the rising clock edge. Output bits change on the falling edge. The port is clocked by the serial clock only. The select line, combined with the block reset, acts as its asynchronous reset.

Top module: `adc_serial_port`

## Requirements
- R1: While rst_ni is low or cs_ni is high, dout_oe_o, dout_o, conv_start_o, sel_o and msbf_o are all 0.
- R2: With cs_ni low, each 0 sampled on din_i at a rising sclk_i edge before the first 1 is ignored. The first 1 sampled is taken as the start bit.
- R3: The three bits sampled at the rising edges after the start bit are, in order, sel_o[1], sel_o[0] and msbf_o. From the edge that samples the third bit until cs_ni rises, sel_o and msbf_o present these captured values.
- R4: conv_start_o is 1 for exactly one sclk_i period. It is set by the rising edge that samples the third configuration bit, and it occurs once per exchange.
- R5: After configuration, din_i has no effect on sel_o, msbf_o, dout_oe_o or dout_o until cs_ni rises.
- R6: dout_oe_o stays 0 while the port is hunting and capturing. It rises on the first falling sclk_i edge after configuration completes.
- R7: Starting with that falling edge, dout_o carries a 0 null bit and then result bits 9 down to 0, one per falling edge.
- R8: With msbf_o = 0, the falling edges after bit 0 carry bits 1 up to 9, and then dout_o stays 0.
- R9: With msbf_o = 1, dout_o stays 0 on every falling edge after bit 0.
- R10: cs_ni rising forces dout_oe_o to 0 without waiting for a clock edge and aborts the exchange. The next fall of cs_ni starts a fresh start-bit hunt.
- R11: result_i is sampled on the falling edge that sends the null bit. Later changes to result_i do not affect the bits sent in the current exchange.
- R12: While dout_oe_o is 0, dout_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Serial clock from the host |
| rst_ni | input | 1 | Active-low asynchronous block reset |
| cs_ni | input | 1 | Active-low select; high aborts and resets the exchange |
| din_i | input | 1 | Serial command input, sampled on rising sclk_i |
| result_i | input | RES_W (10) | Conversion result from the core |
| sel_o | output | SEL_W (2) | Captured channel selection |
| msbf_o | output | 1 | Captured order flag; 1 = MSB-first only |
| conv_start_o | output | 1 | One-period start-of-conversion strobe |
| dout_o | output | 1 | Serial result data, changes on falling sclk_i |
| dout_oe_o | output | 1 | Output enable for the three-state data pad |

## Verification
The bench sweeps every channel selection and both order flags with zero to three leading zeros. The result values are spread to hit all-ones, zero, a single high bit and a single low bit. A design that counted a leading zero as the start bit would capture shifted configuration bits. A design that repeated B0 in the reversed tail would put every later bit one slot late. The bench keeps toggling din_i through the output phase and swaps result_i after the null bit, which exposes a capture path that was not frozen. It also aborts one exchange during capture and one during output. This catches a port that keeps stale state across a select cycle or waits for a clock edge to release the line.

// File: rtl/adc_sport_pkg.sv
package adc_sport_pkg;
  typedef enum logic [1:0] {
    RX_HUNT = 2'd0,
    RX_CFG  = 2'd1,
    RX_DONE = 2'd2
  } rx_state_e;
endpackage

// File: rtl/sport_cmd_rx.sv
module sport_cmd_rx
  import adc_sport_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             sclk_i,
  input  logic             arst_ni,
  input  logic             din_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             msbf_o,
  output logic             done_o,
  output logic             conv_start_o
);
  localparam int CFG_W = SEL_W + 1;
  localparam int CNT_W = $clog2(CFG_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CFG_W - 1);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CFG_W-1:0] cfg_q;
  logic             conv_q;

  always_ff @(posedge sclk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      state_q <= RX_HUNT;
      cnt_q   <= '0;
      cfg_q   <= '0;
      conv_q  <= 1'b0;
    end else begin
      conv_q <= 1'b0;
      unique case (state_q)
        RX_HUNT: begin
          if (din_i) begin
            state_q <= RX_CFG;
            cnt_q   <= '0;
          end
        end
        RX_CFG: begin
          cfg_q <= {cfg_q[CFG_W-2:0], din_i};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) begin
            state_q <= RX_DONE;
            conv_q  <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign done_o       = (state_q == RX_DONE);
  assign sel_o        = done_o ? cfg_q[CFG_W-1:1] : '0;
  assign msbf_o       = done_o & cfg_q[0];
  assign conv_start_o = conv_q;

  // R4
  conv_pulse_chk: assert property (@(posedge sclk_i) disable iff (!arst_ni)
    conv_q |=> !conv_q);

  // R2
  start_bit_chk: assert property (@(posedge sclk_i) disable iff (!arst_ni)
    (state_q == RX_CFG && cnt_q == '0) |-> $past(din_i));
endmodule

// File: rtl/sport_res_tx.sv
module sport_res_tx #(
  parameter int RES_W = 10
) (
  input  logic             sclk_i,
  input  logic             arst_ni,
  input  logic             cfg_done_i,
  input  logic             msbf_i,
  input  logic [RES_W-1:0] result_i,
  output logic             oe_o,
  output logic             bit_o
);
  // slot 1 = null, 2..RES_W+1 = MSB-first, RES_W+2..2*RES_W = LSB repeat, then zeros
  localparam int CNT_W = $clog2(2 * RES_W + 2);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(2 * RES_W + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [RES_W-1:0] res_q;

  always_ff @(negedge sclk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      cnt_q <= '0;
      res_q <= '0;
    end else if (cnt_q == '0) begin
      if (cfg_done_i) begin
        cnt_q <= CNT_W'(1);
        res_q <= result_i;
      end
    end else if (cnt_q != CNT_END) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    int slot;
    slot  = int'(cnt_q);
    bit_o = 1'b0;
    if (slot >= 2 && slot <= RES_W + 1) begin
      bit_o = res_q[RES_W + 1 - slot];
    end else if (!msbf_i && slot >= RES_W + 2 && slot <= 2 * RES_W) begin
      bit_o = res_q[slot - RES_W - 1];
    end
  end

  assign oe_o = (cnt_q != '0);

  // R6
  oe_rise_chk: assert property (@(negedge sclk_i) disable iff (!arst_ni)
    $rose(oe_o) |-> $past(cfg_done_i));

  // R5
  oe_hold_chk: assert property (@(negedge sclk_i) disable iff (!arst_ni)
    oe_o |=> oe_o);
endmodule

// File: rtl/sport_out_drv.sv
module sport_out_drv (
  input  logic cs_ni,
  input  logic oe_i,
  input  logic bit_i,
  output logic dout_o,
  output logic dout_oe_o
);
  assign dout_oe_o = oe_i & ~cs_ni;
  assign dout_o    = dout_oe_o & bit_i;
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int RES_W = 10,
  parameter int SEL_W = 2
) (
  input  logic             sclk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             din_i,
  input  logic [RES_W-1:0] result_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             msbf_o,
  output logic             conv_start_o,
  output logic             dout_o,
  output logic             dout_oe_o
);
  logic arst_n;
  logic cfg_done;
  logic tx_oe;
  logic tx_bit;

  assign arst_n = rst_ni & ~cs_ni;

  sport_cmd_rx #(.SEL_W(SEL_W)) u_rx (
    .sclk_i      (sclk_i),
    .arst_ni     (arst_n),
    .din_i       (din_i),
    .sel_o       (sel_o),
    .msbf_o      (msbf_o),
    .done_o      (cfg_done),
    .conv_start_o(conv_start_o)
  );

  sport_res_tx #(.RES_W(RES_W)) u_tx (
    .sclk_i    (sclk_i),
    .arst_ni   (arst_n),
    .cfg_done_i(cfg_done),
    .msbf_i    (msbf_o),
    .result_i  (result_i),
    .oe_o      (tx_oe),
    .bit_o     (tx_bit)
  );

  sport_out_drv u_drv (
    .cs_ni    (cs_ni),
    .oe_i     (tx_oe),
    .bit_i    (tx_bit),
    .dout_o   (dout_o),
    .dout_oe_o(dout_oe_o)
  );

  // R10
  always_comb begin
    if (rst_ni && cs_ni) begin
      cs_idle_chk: assert (!dout_oe_o);
    end
  end

  // R12
  always_comb begin
    if (rst_ni && !dout_oe_o) begin
      dout_quiet_chk: assert (!dout_o);
    end
  end

  // R3
  conv_cfg_chk: assert property (@(posedge sclk_i) disable iff (!arst_n)
    conv_start_o |-> cfg_done);

  // R5
  sel_hold_chk: assert property (@(posedge sclk_i) disable iff (!arst_n)
    (cfg_done && $past(cfg_done)) |-> ($stable(sel_o) && $stable(msbf_o)));
endmodule

// File: tb/tb_adc_serial_port.sv
module tb_adc_serial_port;
  localparam int RES_W = 10;
  localparam int SEL_W = 2;
  localparam int OUT_SLOTS = 24;

  logic             sclk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cs_ni = 1'b1;
  logic             din = 1'b0;
  logic [RES_W-1:0] result = '0;
  logic [SEL_W-1:0] sel_o;
  logic             msbf_o;
  logic             conv_start_o;
  logic             dout_o;
  logic             dout_oe_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2.5 sclk = ~sclk;

  adc_serial_port #(.RES_W(RES_W), .SEL_W(SEL_W)) dut (
    .sclk_i      (sclk),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_ni),
    .din_i       (din),
    .result_i    (result),
    .sel_o       (sel_o),
    .msbf_o      (msbf_o),
    .conv_start_o(conv_start_o),
    .dout_o      (dout_o),
    .dout_oe_o   (dout_oe_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // drive din in the low phase, sample just after the rising edge
  task automatic step(input logic d);
    @(negedge sclk);
    #1 din = d;
    @(posedge sclk);
    #1;
  endtask

  function automatic logic exp_bit(input int k, input logic [RES_W-1:0] r, input logic m);
    if (k == 0) return 1'b0;
    if (k <= RES_W) return r[RES_W - k];
    if (!m && k <= 2 * RES_W - 1) return r[k - RES_W];
    return 1'b0;
  endfunction

  // abort_at < 0: full exchange; otherwise raise cs after output slot abort_at
  task automatic run_frame(input int z, input int sel, input int m, input int res,
                           input int abort_at);
    logic [RES_W-1:0] r;
    logic [1:0] s;
    r = RES_W'(res);
    s = 2'(sel);
    @(negedge sclk);
    #1 din = 1'b0; cs_ni = 1'b0; result = r;
    for (int i = 0; i < z; i++) begin
      step(1'b0);
      chk(dout_oe_o == 1'b0, "R6 hunt oe", dout_oe_o, 0);
      chk(conv_start_o == 1'b0, "R2 zero taken as start", conv_start_o, 0);
    end
    step(1'b1);
    chk(dout_oe_o == 1'b0, "R6 start oe", dout_oe_o, 0);
    step(s[1]);
    step(s[0]);
    chk(conv_start_o == 1'b0, "R4 early strobe", conv_start_o, 0);
    step(m[0]);
    chk(conv_start_o == 1'b1, "R4 strobe", conv_start_o, 1);
    chk(sel_o == s, "R3 sel", sel_o, s);
    chk(msbf_o == m[0], "R3 msbf", msbf_o, m);
    chk(dout_oe_o == 1'b0, "R6 oe at capture", dout_oe_o, 0);
    for (int k = 0; k < OUT_SLOTS; k++) begin
      step(logic'(((k * 5) + sel + z) % 3 == 0));
      if (k == 0) begin
        chk(conv_start_o == 1'b0, "R4 strobe width", conv_start_o, 0);
        chk(dout_oe_o == 1'b1, "R6 oe rise", dout_oe_o, 1);
        result = ~r;
      end
      chk(dout_oe_o == 1'b1, "R5 oe held", dout_oe_o, 1);
      chk(sel_o == s && msbf_o == m[0], "R5 cfg held", {sel_o, msbf_o}, {s, m[0]});
      if (k <= RES_W)
        chk(dout_o == exp_bit(k, r, m[0]), "R7/R11 msb stream", dout_o, exp_bit(k, r, m[0]));
      else if (m[0])
        chk(dout_o == 1'b0, "R9 tail zero", dout_o, 0);
      else
        chk(dout_o == exp_bit(k, r, m[0]), "R8 lsb repeat", dout_o, exp_bit(k, r, m[0]));
      if (k == abort_at) begin
        cs_ni = 1'b1;
        #0.5;
        chk(dout_oe_o == 1'b0, "R10 async release", dout_oe_o, 0);
        chk(dout_o == 1'b0, "R12 quiet", dout_o, 0);
        return;
      end
    end
    @(negedge sclk);
    #1 cs_ni = 1'b1;
    #0.5;
    chk(dout_oe_o == 1'b0, "R10 release", dout_oe_o, 0);
    chk(sel_o == '0 && msbf_o == 1'b0, "R1 cs high idle", {sel_o, msbf_o}, 0);
  endtask

  initial begin
    #12;
    chk(dout_oe_o == 1'b0 && dout_o == 1'b0, "R1 reset out", {dout_oe_o, dout_o}, 0);
    chk(conv_start_o == 1'b0 && sel_o == '0 && msbf_o == 1'b0, "R1 reset cfg",
        {conv_start_o, sel_o, msbf_o}, 0);
    // select low while held in reset: nothing happens
    cs_ni = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step(1'b1);
      chk(dout_oe_o == 1'b0 && conv_start_o == 1'b0, "R1 reset held", dout_oe_o, 0);
    end
    cs_ni = 1'b1;
    #3 rst_ni = 1'b1;

    for (int z = 0; z < 4; z++)
      for (int s = 0; s < 4; s++)
        for (int m = 0; m < 2; m++)
          run_frame(z, s, m, (s * 197 + z * 311 + m * 523 + 77) % 1024, -1);

    for (int m = 0; m < 2; m++) begin
      run_frame(1, 3, m, 1023, -1);
      run_frame(0, 0, m, 0, -1);
      run_frame(2, 1, m, 512, -1);
      run_frame(3, 2, m, 1, -1);
    end

    // R10 abort during capture, then a fresh hunt
    @(negedge sclk);
    #1 din = 1'b0; cs_ni = 1'b0;
    step(1'b0);
    step(1'b1);
    step(1'b1);
    cs_ni = 1'b1;
    #0.5;
    chk(dout_oe_o == 1'b0 && sel_o == '0, "R10 abort capture", {dout_oe_o, sel_o}, 0);
    run_frame(2, 1, 0, 341, -1);

    // R10 abort during output, then a full exchange
    run_frame(1, 2, 0, 682, 6);
    run_frame(0, 3, 1, 853, -1);

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(posedge sclk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule